// File: doc/BRIEF.md
# Variable-Block Carry-Select Adder

This block adds two 16-bit unsigned operands and an incoming carry, producing a 16-bit sum and an outgoing carry, with no clock and no storage. The operand width is cut into five segments whose widths grow towards the most significant end. The lowest segment is an ordinary one-bit full adder fed by the external carry. Every segment above it computes two candidate results in parallel. One candidate assumes that no carry enters the segment, the other assumes that a carry does.

A two-way selector in each upper segment then keeps one candidate. The selector is steered by the true carry that leaves the segment just below. That chosen carry in turn steers the next selector, so the only serial path across the word is a chain of four selectors. Because the segments widen upward, each segment's candidates finish rippling at roughly the moment its steering carry arrives.

The adder is meant to sit inside a datapath wherever a fast combinational sum is needed. Operands and carry are applied, and the result is read once the logic has settled.

Top module: `csel_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals the 17-bit unsigned value `a_i + b_i + carry_i` for every input combination.
- R2: The word is partitioned from least to most significant into segments of 1, 2, 3, 4 and 6 bits, starting at bit positions 0, 1, 3, 6 and 10. A carry generated below each start position must arrive correctly at that position.
- R3: Bit 0 of the sum is produced by a plain full adder driven directly by `carry_i`: `sum_o[0] = a_i[0] ^ b_i[0] ^ carry_i`.
- R4: Each upper segment forms two ripple-carry candidates of its own width, one for an entering carry of 0 and one for 1. The second candidate equals the first plus one. At the ports, flipping only `carry_i` changes `{carry_o, sum_o}` by exactly one.
- R5: In each upper segment, one selector picks both the sum bits and the outgoing carry of the same candidate, steered by the true carry from the segment below.
- R6: A carry entering at bit 0 propagates through every selector. `0xFFFF + 0x0000` with `carry_i = 1` gives sum `0x0000` and `carry_o = 1`.
- R7: `carry_o` is the carry chosen by the selector of the most significant 6-bit segment. It is 1 exactly when the 17-bit sum exceeds `0xFFFF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| carry_i | input | 1 | Incoming carry at bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Outgoing carry from bit 15 |

## Verification
The two functions that can coincide are carry generation inside a segment and carry selection by the chain below. When an operand is all ones up to a segment's start position and the incoming carry is 1, both happen at once. The carry born at bit 0 must steer the selector of that segment at the same time as that segment's own candidates decide its output carry. The bench provokes this with an all-ones low field at every segment start (1, 3, 6, 10 and 16 bits) and with the full all-ones-plus-one case. It then sends each case a second time with the incoming carry cleared. Every result is judged against a 17-bit sum computed in the bench.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int NBLK = 5;
    localparam int SEG_W [NBLK] = '{1, 2, 3, 4, 6};

    function automatic int seg_lo(input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < NBLK; j++) begin
            if (j < k) acc += SEG_W[j];
        end
        return acc;
    endfunction

    localparam int WIDTH = seg_lo(NBLK);
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    logic [W:0] cy;

    assign cy[0] = c_i;

    for (genvar g = 0; g < W; g++) begin : g_fa
        logic half_d;
        assign half_d    = a_i[g] ^ b_i[g];
        assign s_o[g]    = half_d ^ cy[g];
        assign cy[g+1]   = (a_i[g] & b_i[g]) | (cy[g] & half_d);
    end

    assign c_o = cy[W];

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i})) begin
            assert_ripple_sum_R1: assert ({c_o, s_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)))
                else $error("ripple segment sum mismatch");
        end
    end
endmodule

// File: rtl/csel_select.sv
module csel_select #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    typedef struct packed {
        logic         carry;
        logic [W-1:0] sum;
    } cand_t;

    cand_t zero_d, one_d, pick_d;

    csel_ripple #(.W(W)) u_zero (
        .a_i(a_i), .b_i(b_i), .c_i(1'b0),
        .s_o(zero_d.sum), .c_o(zero_d.carry)
    );

    csel_ripple #(.W(W)) u_one (
        .a_i(a_i), .b_i(b_i), .c_i(1'b1),
        .s_o(one_d.sum), .c_o(one_d.carry)
    );

    always_comb begin
        pick_d = sel_i ? one_d : zero_d;
    end

    assign s_o = pick_d.sum;
    assign c_o = pick_d.carry;

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            assert_cand_step_R4: assert ({1'b0, one_d} == ({1'b0, zero_d} + (W+2)'(1)))
                else $error("speculative candidates differ by other than one");
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic        carry_i,
    output logic [15:0] sum_o,
    output logic        carry_o
);
    logic [NBLK:0]    chain_d;
    logic [WIDTH-1:0] sum_d;

    assign chain_d[0] = carry_i;

    for (genvar k = 0; k < NBLK; k++) begin : g_seg
        localparam int LO = seg_lo(k);
        localparam int W  = SEG_W[k];
        if (k == 0) begin : g_base
            csel_ripple #(.W(W)) u_fa (
                .a_i(a_i[LO +: W]), .b_i(b_i[LO +: W]), .c_i(chain_d[k]),
                .s_o(sum_d[LO +: W]), .c_o(chain_d[k+1])
            );
        end else begin : g_spec
            csel_select #(.W(W)) u_sel (
                .a_i(a_i[LO +: W]), .b_i(b_i[LO +: W]), .sel_i(chain_d[k]),
                .s_o(sum_d[LO +: W]), .c_o(chain_d[k+1])
            );
        end
    end

    assign sum_o   = sum_d;
    assign carry_o = chain_d[NBLK];

    always_comb begin
        if (!$isunknown({a_i, b_i, carry_i})) begin
            assert_total_sum_R1: assert ({carry_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + 17'(carry_i)))
                else $error("adder result mismatch");
            assert_bit0_R3: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ carry_i))
                else $error("bit 0 mismatch");
            assert_carry_out_R7: assert (carry_o ==
                (({1'b0, a_i} + {1'b0, b_i} + 17'(carry_i)) > 17'h0FFFF))
                else $error("carry out mismatch");
        end
    end
endmodule

// File: tb/sim_csel_adder.sv
module sim_csel_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] sum_o;
    logic        carry_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [16:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    item_t cur;

    always #10 clk = ~clk;

    csel_adder u0 (
        .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
        .sum_o(sum_o), .carry_o(carry_o)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic c, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a_i = a;
        b_i = b;
        carry_i = c;
        it.exp = {1'b0, a} + {1'b0, b} + 17'(c);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            checks++;
            if ({carry_o, sum_o} !== cur.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", cur.tag, {carry_o, sum_o}, cur.exp);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(16'h0000, 16'h0000, 1'b0, "R1 reset state zero");
        drive(16'h0000, 16'h0000, 1'b1, "R3 carry only");
        drive(16'h0001, 16'h0001, 1'b1, "R3 bit0 full adder");
        // R2/R6: all-ones below each segment start plus incoming carry
        for (int k = 0; k < 5; k++) begin
            int pos;
            logic [16:0] low;
            pos = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 6 : (k == 3) ? 10 : 16;
            low = (17'h1 << pos) - 17'h1;
            drive(low[15:0], 16'h0000, 1'b1, "R2 R6 boundary carry");
            drive(low[15:0], 16'h0000, 1'b0, "R4 boundary no carry");
        end
        drive(16'hFFFF, 16'h0000, 1'b1, "R6 all ones plus one");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R7 max carry out");
        drive(16'h8000, 16'h8000, 1'b0, "R7 top segment carry");
        drive(16'h03FF, 16'h0001, 1'b0, "R5 generated carry selects top segment");
        drive(16'h1234, 16'h0FCB, 1'b0, "R4 carry flip low");
        drive(16'h1234, 16'h0FCB, 1'b1, "R4 carry flip high");
        drive(16'h0155, 16'h00AA, 1'b1, "R5 propagate chain");
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom());
            rb = 16'($urandom());
            drive(ra, rb, 1'b0, "R1 random cin0");
            drive(ra, rb, 1'b1, "R4 random cin1");
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule